// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is the control side of one DMA channel. A start pulse latches a 32-bit source address, a 32-bit destination address, a 24-bit transfer count and the channel configuration. The configuration sets the unit size, the per-address stepping mode and either dual or single addressing. After that, every unit-done strobe from the bus side advances the channel by one unit. The addresses that are set to move step up or down by the unit size, and the remaining count drops by one. The block drives no bus cycles of its own. An external bus model performs each transfer and reports its completion with the strobe.

In dual address mode both addresses advance. In single address mode only the memory-side address advances. A direction input picks which side is memory. The device side is reached through an acknowledge output that stays high while the channel is transferring. A sticky half flag rises when the remaining count first reaches half the starting count. An end flag rises when the count runs out. The channel then drops its active state and holds the end flag until software clears it.

The sequencer has three named states. IDLE moves to XFER on a start pulse (transition T_START). XFER moves to DONE on the unit-done strobe of the last unit (transition T_LAST). DONE moves back to IDLE when the end flag is cleared (transition T_ACK_END). Every other input leaves the state unchanged.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the channel is in IDLE. `active`, `dev_ack`, `half_irq` and `end_irq` are 0, and `src_addr`, `dst_addr` and `count_left` are 0.
- R2: A `go` pulse in IDLE loads `src_init`, `dst_init`, `cnt_init` and the configuration, clears `half_irq` and enters XFER, all on the next edge. A `go` pulse while the channel is not in IDLE is ignored: the count and the addresses are not reloaded.
- R3: The unit size `cfg_size` is encoded 00 = 1 byte, 01 = 2 bytes, 10 = 4 bytes and 11 = 16 bytes. A moving address changes by exactly that many bytes per unit.
- R4: The address mode fields `cfg_src_mode` and `cfg_dst_mode` are encoded 00 = fixed, 01 = increment, 10 = decrement and 11 = fixed.
- R5: Each `unit_done` in XFER lowers `count_left` by one. A `unit_done` outside XFER changes nothing.
- R6: A `cnt_init` of 0 means 2^24 transfers. `count_left` shows 0 right after the load, then 0xFFFFFF, 0xFFFFFE and so on, and the channel stays in XFER.
- R7: For a starting count N, `half_irq` is set on the unit that leaves floor(N/2) units remaining, and on no earlier unit. It stays set until `clr_half` or the next accepted `go`.
- R8: The unit that brings the count to 0 moves the channel to DONE. `active` then reads 0 and `end_irq` reads 1. `end_irq` stays 1 until `clr_end`, which returns the channel to IDLE and keeps the addresses.
- R9: In single address mode (`cfg_single` = 1), `cfg_mem_dst` = 0 makes the source the memory side, so only `src_addr` moves. `cfg_mem_dst` = 1 makes only `dst_addr` move. `dev_ack` is high throughout XFER in single mode and is always 0 in dual mode.
- R10: In dual address mode both addresses advance by their own modes on every unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start pulse; loads the channel from IDLE |
| src_init | input | 32 | Source start address |
| dst_init | input | 32 | Destination start address |
| cnt_init | input | 24 | Transfer count; 0 means 2^24 |
| cfg_size | input | 2 | Unit size code |
| cfg_src_mode | input | 2 | Source address stepping mode |
| cfg_dst_mode | input | 2 | Destination address stepping mode |
| cfg_single | input | 1 | 1 = single address mode |
| cfg_mem_dst | input | 1 | Single mode: 1 = memory is the destination |
| unit_done | input | 1 | One unit finished on the bus |
| clr_half | input | 1 | Clears the half flag |
| clr_end | input | 1 | Clears the end flag, back to IDLE |
| src_addr | output | 32 | Current source address |
| dst_addr | output | 32 | Current destination address |
| count_left | output | 24 | Remaining units (low 24 bits) |
| active | output | 1 | Channel enable, high in XFER |
| dev_ack | output | 1 | Device acknowledge in single mode |
| half_irq | output | 1 | Half-way flag |
| end_irq | output | 1 | Completion flag |

## Verification
The bench tests odd and tiny counts. With N = 5 the half flag must wait for the third unit, and a design that rounds half upward would raise it one unit early. With N = 1 the half flag and the end flag must rise together on the same unit. A zero count must run as 2^24 transfers, so a design that treats it as empty would end at once, and one that wraps wrongly would show a bad `count_left`.

Every size and address mode is driven, including the reserved mode 11, which a loose decoder might treat as increment. Single mode is run in both directions to catch a device-side address that moves when it should stay put. Stray `go` and `unit_done` pulses are applied in the wrong states to expose reloads, or counting while the channel is idle or done.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        UNIT_BYTE  = 2'b00,
        UNIT_WORD  = 2'b01,
        UNIT_LONG  = 2'b10,
        UNIT_BLOCK = 2'b11
    } unit_e;

    typedef enum logic [1:0] {
        AM_FIX = 2'b00,
        AM_INC = 2'b01,
        AM_DEC = 2'b10,
        AM_RSV = 2'b11
    } amode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_XFER = 2'b01,
        ST_DONE = 2'b10
    } seq_st_e;

    function automatic logic [4:0] unit_bytes(unit_e u);
        unique case (u)
            UNIT_BYTE:  return 5'd1;
            UNIT_WORD:  return 5'd2;
            UNIT_LONG:  return 5'd4;
            UNIT_BLOCK: return 5'd16;
            default:    return 5'd1;
        endcase
    endfunction

endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step
    import dma_seq_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] init,
    input  logic          adv,
    input  amode_e        mode,
    input  unit_e         size,
    output logic [AW-1:0] addr
);
    localparam int PADW = AW - 5;

    logic [AW-1:0] step;
    assign step = {{PADW{1'b0}}, unit_bytes(size)};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load) begin
            addr <= init;
        end else if (adv) begin
            unique case (mode)
                AM_INC:  addr <= addr + step;
                AM_DEC:  addr <= addr - step;
                default: addr <= addr;
            endcase
        end
    end

    // R4
    fix_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !load && (mode == AM_FIX || mode == AM_RSV)) |=> $stable(addr));

endmodule

// File: rtl/dma_count_unit.sv
module dma_count_unit #(
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] init,
    input  logic          dec,
    output logic [CW:0]   rem,
    output logic          half_hit,
    output logic          last
);
    localparam logic [CW:0] FULL = {1'b1, {CW{1'b0}}};
    localparam logic [CW:0] ONE  = {{CW{1'b0}}, 1'b1};

    logic [CW:0]   ld_val;
    logic [CW-1:0] half_pt;

    assign ld_val = (init == '0) ? FULL : {1'b0, init};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem     <= '0;
            half_pt <= '0;
        end else if (load) begin
            rem     <= ld_val;
            half_pt <= ld_val[CW:1];
        end else if (dec) begin
            rem     <= rem - ONE;
        end
    end

    assign last     = (rem == ONE);
    assign half_hit = dec && ((rem - ONE) == {1'b0, half_pt});

    // R5
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (rem == $past(rem) - ONE));

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go,
    input  logic    unit_done,
    input  logic    last,
    input  logic    clr_end,
    output seq_st_e state,
    output logic    load,
    output logic    adv,
    output logic    active,
    output logic    end_flag
);
    seq_st_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (go) nxt = ST_XFER;
            ST_XFER: if (unit_done && last) nxt = ST_DONE;
            ST_DONE: if (clr_end) nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        load     = 1'b0;
        adv      = 1'b0;
        active   = 1'b0;
        end_flag = 1'b0;
        unique case (state)
            ST_IDLE: load = go;
            ST_XFER: begin
                adv    = unit_done;
                active = 1'b1;
            end
            ST_DONE: end_flag = 1'b1;
            default: ;
        endcase
    end

    // R2
    go_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && !(unit_done && last)) |=> (state == ST_XFER));

    // R8
    end_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE && !clr_end) |=> (state == ST_DONE));

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [AW-1:0] src_init,
    input  logic [AW-1:0] dst_init,
    input  logic [CW-1:0] cnt_init,
    input  logic [1:0]    cfg_size,
    input  logic [1:0]    cfg_src_mode,
    input  logic [1:0]    cfg_dst_mode,
    input  logic          cfg_single,
    input  logic          cfg_mem_dst,
    input  logic          unit_done,
    input  logic          clr_half,
    input  logic          clr_end,
    output logic [AW-1:0] src_addr,
    output logic [AW-1:0] dst_addr,
    output logic [CW-1:0] count_left,
    output logic          active,
    output logic          dev_ack,
    output logic          half_irq,
    output logic          end_irq
);
    seq_st_e     state;
    logic        load, adv, last, half_hit;
    logic [CW:0] rem;
    unit_e       size_q;
    amode_e      smode_q, dmode_q;
    logic        single_q, memdst_q;
    logic        adv_src, adv_dst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q   <= UNIT_BYTE;
            smode_q  <= AM_FIX;
            dmode_q  <= AM_FIX;
            single_q <= 1'b0;
            memdst_q <= 1'b0;
        end else if (load) begin
            size_q   <= unit_e'(cfg_size);
            smode_q  <= amode_e'(cfg_src_mode);
            dmode_q  <= amode_e'(cfg_dst_mode);
            single_q <= cfg_single;
            memdst_q <= cfg_mem_dst;
        end
    end

    dma_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .unit_done(unit_done),
        .last     (last),
        .clr_end  (clr_end),
        .state    (state),
        .load     (load),
        .adv      (adv),
        .active   (active),
        .end_flag (end_irq)
    );

    dma_count_unit #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .init    (cnt_init),
        .dec     (adv),
        .rem     (rem),
        .half_hit(half_hit),
        .last    (last)
    );

    assign adv_src = adv && (!single_q || !memdst_q);
    assign adv_dst = adv && (!single_q ||  memdst_q);

    dma_addr_step #(.AW(AW)) u_src (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .init (src_init),
        .adv  (adv_src),
        .mode (smode_q),
        .size (size_q),
        .addr (src_addr)
    );

    dma_addr_step #(.AW(AW)) u_dst (
        .clk  (clk),
        .rst_n(rst_n),
        .load (load),
        .init (dst_init),
        .adv  (adv_dst),
        .mode (dmode_q),
        .size (size_q),
        .addr (dst_addr)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        half_irq <= 1'b0;
        else if (load)     half_irq <= 1'b0;
        else if (half_hit) half_irq <= 1'b1;
        else if (clr_half) half_irq <= 1'b0;
    end

    assign count_left = rem[CW-1:0];
    assign dev_ack    = active && single_q;

    // R9
    ack_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> (state == ST_XFER && single_q));

    // R8
    end_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        end_irq |-> (!active && rem == '0));

endmodule

// File: tb/tb_dma_chan_seq.sv
module tb_dma_chan_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        go = 0, unit_done = 0, clr_half = 0, clr_end = 0;
    logic [31:0] src_init = 0, dst_init = 0;
    logic [23:0] cnt_init = 0;
    logic [1:0]  cfg_size = 0, cfg_src_mode = 0, cfg_dst_mode = 0;
    logic        cfg_single = 0, cfg_mem_dst = 0;
    logic [31:0] src_addr, dst_addr;
    logic [23:0] count_left;
    logic        active, dev_ack, half_irq, end_irq;

    int tests = 0;
    int fails = 0;

    always #4 clk = ~clk;

    dma_chan_seq dut (
        .clk(clk), .rst_n(rst_n), .go(go), .src_init(src_init), .dst_init(dst_init),
        .cnt_init(cnt_init), .cfg_size(cfg_size), .cfg_src_mode(cfg_src_mode),
        .cfg_dst_mode(cfg_dst_mode), .cfg_single(cfg_single), .cfg_mem_dst(cfg_mem_dst),
        .unit_done(unit_done), .clr_half(clr_half), .clr_end(clr_end),
        .src_addr(src_addr), .dst_addr(dst_addr), .count_left(count_left),
        .active(active), .dev_ack(dev_ack), .half_irq(half_irq), .end_irq(end_irq)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(negedge clk); rst_n = 1;
    endtask

    task automatic start(input logic [31:0] s, input logic [31:0] d, input logic [23:0] n,
                         input logic [1:0] sz, input logic [1:0] sm, input logic [1:0] dm,
                         input logic sg, input logic md);
        @(negedge clk);
        src_init = s; dst_init = d; cnt_init = n; cfg_size = sz;
        cfg_src_mode = sm; cfg_dst_mode = dm; cfg_single = sg; cfg_mem_dst = md; go = 1;
        @(negedge clk); go = 0;
    endtask

    task automatic units(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); unit_done = 1;
            @(negedge clk); unit_done = 0;
        end
    endtask

    task automatic pulse_clr_end();
        @(negedge clk); clr_end = 1;
        @(negedge clk); clr_end = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(!active && !dev_ack && !half_irq && !end_irq, "R1 flags", {active,dev_ack,half_irq,end_irq}, 0);
        chk(src_addr == 0 && dst_addr == 0 && count_left == 0, "R1 regs", src_addr, 0);
    endtask

    task automatic t_dual_word();
        start(32'h1000, 32'h2000, 24'd4, 2'b01, 2'b01, 2'b10, 0, 0);
        chk(active && count_left == 4, "R2 load", count_left, 4);
        chk(src_addr == 32'h1000 && dst_addr == 32'h2000, "R2 addr load", dst_addr, 32'h2000);
        chk(!dev_ack, "R9 no ack in dual", dev_ack, 0);
        units(1);
        chk(src_addr == 32'h1002, "R10 src inc word", src_addr, 32'h1002);
        chk(dst_addr == 32'h1FFE, "R10 dst dec word", dst_addr, 32'h1FFE);
        chk(count_left == 3 && !half_irq, "R5 count", count_left, 3);
        units(1);
        chk(half_irq, "R7 half at 2 of 4", half_irq, 1);
        start(32'hDEAD, 32'hBEEF, 24'd9, 2'b00, 2'b00, 2'b00, 0, 0);
        chk(count_left == 2 && src_addr == 32'h1004, "R2 go ignored in XFER", count_left, 2);
        units(2);
        chk(!active && end_irq && count_left == 0, "R8 end", {active,end_irq}, 1);
        chk(src_addr == 32'h1008 && dst_addr == 32'h1FF8, "R8 final addr", src_addr, 32'h1008);
        units(1);
        chk(count_left == 0 && src_addr == 32'h1008 && end_irq, "R5 unit ignored in DONE", count_left, 0);
        start(32'hDEAD, 32'hBEEF, 24'd9, 2'b00, 2'b00, 2'b00, 0, 0);
        chk(end_irq && src_addr == 32'h1008, "R2 go ignored in DONE", src_addr, 32'h1008);
        pulse_clr_end();
        chk(!end_irq && !active && src_addr == 32'h1008, "R8 clr_end to idle", end_irq, 0);
        units(1);
        chk(count_left == 0 && src_addr == 32'h1008, "R5 unit ignored in IDLE", src_addr, 32'h1008);
        @(negedge clk); clr_half = 1; @(negedge clk); clr_half = 0;
        chk(!half_irq, "R7 clr_half", half_irq, 0);
    endtask

    task automatic t_sizes();
        logic [31:0] exp_step [4] = '{1, 2, 4, 16};
        for (int k = 0; k < 4; k++) begin
            start(32'h100, 32'h800, 24'd2, 2'(k), 2'b01, 2'b10, 0, 0);
            units(1);
            chk(src_addr == 32'h100 + exp_step[k], "R3 size src", src_addr, 32'h100 + exp_step[k]);
            chk(dst_addr == 32'h800 - exp_step[k], "R3 size dst", dst_addr, 32'h800 - exp_step[k]);
            units(1);
            pulse_clr_end();
        end
    endtask

    task automatic t_fixed();
        start(32'h40, 32'h80, 24'd3, 2'b10, 2'b00, 2'b11, 0, 0);
        units(2);
        chk(src_addr == 32'h40, "R4 mode 00 fixed", src_addr, 32'h40);
        chk(dst_addr == 32'h80, "R4 mode 11 fixed", dst_addr, 32'h80);
        units(1);
        pulse_clr_end();
    endtask

    task automatic t_single();
        start(32'h3000, 32'h5000, 24'd2, 2'b10, 2'b01, 2'b01, 1, 0);
        chk(dev_ack, "R9 ack in single", dev_ack, 1);
        units(1);
        chk(src_addr == 32'h3004 && dst_addr == 32'h5000, "R9 mem src", dst_addr, 32'h5000);
        units(1);
        chk(!dev_ack, "R9 ack drops at end", dev_ack, 0);
        pulse_clr_end();
        start(32'h3000, 32'h5000, 24'd2, 2'b10, 2'b01, 2'b01, 1, 1);
        units(1);
        chk(src_addr == 32'h3000 && dst_addr == 32'h5004, "R9 mem dst", src_addr, 32'h3000);
        units(1);
        pulse_clr_end();
    endtask

    task automatic t_half_odd();
        start(0, 0, 24'd5, 0, 0, 0, 0, 0);
        units(2);
        chk(!half_irq, "R7 not early N=5", half_irq, 0);
        units(1);
        chk(half_irq, "R7 half N=5", half_irq, 1);
        units(2);
        pulse_clr_end();
        start(0, 0, 24'd1, 0, 0, 0, 0, 0);
        chk(!half_irq, "R2 go clears half", half_irq, 0);
        units(1);
        chk(half_irq && end_irq, "R7 N=1 half with end", {half_irq,end_irq}, 3);
        pulse_clr_end();
    endtask

    task automatic t_zero();
        start(0, 0, 24'd0, 0, 2'b01, 0, 0, 0);
        chk(active && count_left == 0, "R6 zero load", count_left, 0);
        units(3);
        chk(active && !end_irq && count_left == 24'hFFFFFD, "R6 zero runs", count_left, 24'hFFFFFD);
        chk(src_addr == 3, "R6 zero addr", src_addr, 3);
        do_reset();
    endtask

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_dual_word();
        t_sizes();
        t_fixed();
        t_single();
        t_half_odd();
        t_zero();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule